// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Bank

This block is the host-side register bank for four 12-bit digital-to-analog channels, named A to D. The host issues one request per cycle on a request channel that carries a write flag, an address and write data. Data writes go to a shadow register for each channel. A mode register holds two bits: one turns the outputs on and one picks buffered operation. In buffered operation the shadow values reach the output codes only when the host reads the data-update address, and that read moves all four channels together. Without buffering, each data write goes straight to its channel's output.

Each channel also has a range setting made of a bipolar flag and a gain flag. All of them sit in one packed control word, and the bits run in reverse channel order. A host read of the control address copies the shadow control word into the active range outputs. Both commits come from reads, so the read data is never used and the block returns none. While the outputs are off, every channel shows the mid-scale code 0x800 and both commit reads are ignored.

The request channel uses valid/ready. `req_ready` is always high, so the block never applies back-pressure, and a request takes effect in the cycle in which `req_valid` is high.

Top module: `dac_bank`

## Requirements
- R1: After reset, `dac_en_o` is 0, every channel code is 0x800, and `bipolar_o` and `gain_o` are 0. All shadow and active data registers and the control word are cleared, so enabling unbuffered mode straight after reset gives code 0x000 on every channel.
- R2: A write to address 0x14 + 2*i (0x14 A, 0x16 B, 0x18 C, 0x1A D) loads channel i's shadow with wdata[11:0]. The upper bits are dropped. Channel i's code is `dac_code_o[12*i +: 12]`.
- R3: When mode bit 0 is 0, a data write also loads that channel's active register. This happens whether or not the outputs are enabled.
- R4: When mode bit 0 is 1, a data write leaves the outputs unchanged. An enabled read of address 0x02 copies all four shadows into the active registers at once.
- R5: A write to 0x12 loads the shadow control word. The bipolar flags of A, B, C and D are wdata bits 7, 6, 5 and 4, and the gain flags are bits 11, 10, 9 and 8. An enabled read of 0x12 makes them active on `bipolar_o[i]` and `gain_o[i]`, where index 0 is channel A.
- R6: A write to 0x02 sets the mode register: wdata bit 1 enables the outputs (`dac_en_o`) and bit 0 selects buffered mode.
- R7: While the outputs are disabled, every code is 0x800, and reads of 0x02 and 0x12 change nothing. The range outputs keep their last active values.
- R8: `req_ready` is always 1. A request with `req_valid` low, or to an unmapped address, has no effect.
- R9: Every output change shows in the cycle after the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Always 1; no back-pressure |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (6) | Byte address of the register |
| req_wdata | input | 16 | Write data |
| dac_en_o | output | 1 | Outputs enabled |
| dac_code_o | output | NCH*DW (48) | Channel codes; channel i in bits 12*i+11:12*i |
| bipolar_o | output | NCH (4) | Active bipolar flag for each channel, bit 0 = A |
| gain_o | output | NCH (4) | Active gain flag for each channel, bit 0 = A |

## Verification
The bench builds the block with its default values: four channels, 12-bit codes and a 6-bit address. These values put every register offset and every bit of the reversed control packing within reach. The stimulus moves between unbuffered and buffered mode and between enabled and disabled outputs. This shows that direct writes reach the outputs, that buffered writes wait for the update read, and that commit reads issued while disabled leave the state alone. A reset in the middle of the run confirms that the shadow state is cleared as well as the outputs.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int unsigned HOST_DW = 16;
  localparam logic [15:0] OFS_MODE  = 16'h0002;
  localparam logic [15:0] OFS_RANGE = 16'h0012;
  localparam logic [15:0] OFS_DATA0 = 16'h0014;
  localparam int unsigned DATA_STRIDE = 2;
  localparam int unsigned MODE_EN_BIT  = 1;
  localparam int unsigned MODE_BUF_BIT = 0;
  localparam int unsigned RANGE_LO = 4;

  typedef struct packed {
    logic wr_mode;
    logic wr_range;
    logic rd_data_commit;
    logic rd_range_commit;
  } strobe_t;
endpackage

// File: rtl/dac_bank_decode.sv
module dac_bank_decode
  import dac_bank_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 6
) (
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  output strobe_t       strb,
  output logic [NCH-1:0] wr_chan
);
  logic do_wr, do_rd;
  assign do_wr = req_valid && req_write;
  assign do_rd = req_valid && !req_write;

  always_comb begin
    strb.wr_mode         = do_wr && (req_addr == AW'(OFS_MODE));
    strb.wr_range        = do_wr && (req_addr == AW'(OFS_RANGE));
    strb.rd_data_commit  = do_rd && (req_addr == AW'(OFS_MODE));
    strb.rd_range_commit = do_rd && (req_addr == AW'(OFS_RANGE));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan_dec
    localparam logic [AW-1:0] CH_ADDR = AW'(OFS_DATA0 + 16'(i * DATA_STRIDE));
    assign wr_chan[i] = do_wr && (req_addr == CH_ADDR);
  end
endmodule

// File: rtl/dac_bank_data.sv
module dac_bank_data #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wr_chan,
  input  logic [DW-1:0]     wr_code,
  input  logic              commit,
  input  logic              enabled,
  input  logic              buffered,
  output logic [NCH*DW-1:0] codes
);
  localparam logic [DW-1:0] MID_CODE = DW'(1) << (DW - 1);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] shadow_q, active_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (wr_chan[i]) shadow_q <= wr_code;
        if (wr_chan[i] && !buffered) active_q <= wr_code;
        else if (commit && enabled) active_q <= shadow_q;
      end
    end
    assign codes[i*DW +: DW] = enabled ? active_q : MID_CODE;
  end
endmodule

// File: rtl/dac_bank_range.sv
module dac_bank_range #(
  parameter int unsigned NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_range,
  input  logic [2*NCH-1:0] wr_field,
  input  logic             commit,
  input  logic             enabled,
  output logic [NCH-1:0]   bipolar,
  output logic [NCH-1:0]   gain
);
  localparam int unsigned FW = 2 * NCH;
  logic [FW-1:0] shadow_q, active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_range) shadow_q <= wr_field;
      if (commit && enabled) active_q <= shadow_q;
    end
  end

  // Channel 0 owns the top bit of each half: reverse packing.
  for (genvar i = 0; i < NCH; i++) begin : g_unpack
    assign bipolar[i] = active_q[NCH - 1 - i];
    assign gain[i]    = active_q[FW - 1 - i];
  end
endmodule

// File: rtl/dac_bank.sv
module dac_bank
  import dac_bank_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12,
  parameter int unsigned AW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [15:0]       req_wdata,
  output logic              dac_en_o,
  output logic [NCH*DW-1:0] dac_code_o,
  output logic [NCH-1:0]    bipolar_o,
  output logic [NCH-1:0]    gain_o
);
  localparam int unsigned FW = 2 * NCH;

  strobe_t        strb;
  logic [NCH-1:0] wr_chan;
  logic           en_q, buf_q;
  logic           unused_wdata;

  assign req_ready    = 1'b1;
  assign unused_wdata = ^req_wdata;

  dac_bank_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .strb      (strb),
    .wr_chan   (wr_chan)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      buf_q <= 1'b0;
    end else if (strb.wr_mode) begin
      en_q  <= req_wdata[MODE_EN_BIT];
      buf_q <= req_wdata[MODE_BUF_BIT];
    end
  end
  assign dac_en_o = en_q;

  dac_bank_data #(.NCH(NCH), .DW(DW)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_chan  (wr_chan),
    .wr_code  (req_wdata[DW-1:0]),
    .commit   (strb.rd_data_commit),
    .enabled  (en_q),
    .buffered (buf_q),
    .codes    (dac_code_o)
  );

  dac_bank_range #(.NCH(NCH)) u_range (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_range (strb.wr_range),
    .wr_field (req_wdata[RANGE_LO +: FW]),
    .commit   (strb.rd_range_commit),
    .enabled  (en_q),
    .bipolar  (bipolar_o),
    .gain     (gain_o)
  );
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12,
  parameter int unsigned AW  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic              en_q,
  input logic              buf_q,
  input logic [NCH*DW-1:0] dac_code_o,
  input logic [NCH-1:0]    bipolar_o
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);
  localparam logic [AW-1:0] A_LO = AW'(16'h14);
  localparam logic [AW-1:0] A_HI = AW'(16'h14 + 16'(2 * (NCH - 1)));

  logic data_wr, range_rd;
  assign data_wr  = req_valid && req_write && !req_addr[0] &&
                    (req_addr >= A_LO) && (req_addr <= A_HI);
  assign range_rd = req_valid && !req_write && (req_addr == AW'(16'h12));

  assert_midscale_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (dac_code_o == {NCH{MID}}));

  assert_range_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(range_rd && en_q) |=> $stable(bipolar_o));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(dac_code_o));

  assert_buffered_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && buf_q && en_q) |=> $stable(dac_code_o));
endmodule

bind dac_bank dac_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .en_q       (en_q),
  .buf_q      (buf_q),
  .dac_code_o (dac_code_o),
  .bipolar_o  (bipolar_o)
);

// File: tb/dac_bank_test.sv
`timescale 1ns/1ps
module dac_bank_test;
  localparam int NCH = 4, DW = 12, AW = 6;
  localparam logic [47:0] MID4 = {4{12'h800}};
  localparam int NV = 21;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, dac_en_o;
  logic [NCH*DW-1:0] dac_code_o;
  logic [NCH-1:0] bipolar_o, gain_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dac_bank #(.NCH(NCH), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .dac_en_o(dac_en_o), .dac_code_o(dac_code_o),
    .bipolar_o(bipolar_o), .gain_o(gain_o));

  // {valid, write, addr[5:0], wdata[15:0], codes{D,C,B,A}[47:0], bipolar[3:0], gain[3:0]}
  localparam logic [79:0] VEC [NV] = '{
    {1'b1,1'b1,6'h14,16'h0123, MID4, 4'h0,4'h0},                               // R7 direct write while off
    {1'b1,1'b0,6'h02,16'h0000, MID4, 4'h0,4'h0},                               // R7 commit while off
    {1'b1,1'b1,6'h02,16'h0002, {12'h000,12'h000,12'h000,12'h123}, 4'h0,4'h0},  // R6 enable, R3
    {1'b1,1'b1,6'h16,16'hF456, {12'h000,12'h000,12'h456,12'h123}, 4'h0,4'h0},  // R2 mask, R3
    {1'b1,1'b1,6'h02,16'h0003, {12'h000,12'h000,12'h456,12'h123}, 4'h0,4'h0},  // R6 buffered
    {1'b1,1'b1,6'h18,16'h0ABC, {12'h000,12'h000,12'h456,12'h123}, 4'h0,4'h0},  // R4
    {1'b1,1'b1,6'h1A,16'h07FF, {12'h000,12'h000,12'h456,12'h123}, 4'h0,4'h0},  // R4
    {1'b1,1'b1,6'h14,16'h0001, {12'h000,12'h000,12'h456,12'h123}, 4'h0,4'h0},  // R4
    {1'b0,1'b1,6'h14,16'h0555, {12'h000,12'h000,12'h456,12'h123}, 4'h0,4'h0},  // R8 valid low
    {1'b1,1'b1,6'h20,16'h0FFF, {12'h000,12'h000,12'h456,12'h123}, 4'h0,4'h0},  // R8 unmapped
    {1'b1,1'b0,6'h02,16'h0000, {12'h7FF,12'hABC,12'h456,12'h001}, 4'h0,4'h0},  // R4 commit all
    {1'b1,1'b1,6'h12,16'h0A50, {12'h7FF,12'hABC,12'h456,12'h001}, 4'h0,4'h0},  // R5 shadow only
    {1'b1,1'b0,6'h12,16'h0000, {12'h7FF,12'hABC,12'h456,12'h001}, 4'hA,4'h5},  // R5 commit
    {1'b1,1'b1,6'h02,16'h0001, MID4, 4'hA,4'h5},                               // R7 disable
    {1'b1,1'b1,6'h12,16'h0FF0, MID4, 4'hA,4'h5},                               // R5
    {1'b1,1'b0,6'h12,16'h0000, MID4, 4'hA,4'h5},                               // R7 range commit ignored
    {1'b1,1'b1,6'h16,16'h0999, MID4, 4'hA,4'h5},                               // R4
    {1'b1,1'b0,6'h02,16'h0000, MID4, 4'hA,4'h5},                               // R7 data commit ignored
    {1'b1,1'b1,6'h02,16'h0003, {12'h7FF,12'hABC,12'h456,12'h001}, 4'hA,4'h5},  // R7 R9
    {1'b1,1'b0,6'h12,16'h0000, {12'h7FF,12'hABC,12'h456,12'h001}, 4'hF,4'hF},  // R5
    {1'b1,1'b0,6'h02,16'h0000, {12'h7FF,12'hABC,12'h999,12'h001}, 4'hF,4'hF}   // R4 R9
  };
  localparam string TAG [NV] = '{"R7","R7","R6/R3","R2/R3","R6","R4","R4","R4",
    "R8","R8","R4","R5","R5","R7","R5","R7","R4","R7","R7/R9","R5","R4/R9"};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [AW-1:0] a, input logic [15:0] d);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 en", 64'(dac_en_o), 64'h0);
    chk("R1 codes", 64'(dac_code_o), 64'(MID4));
    chk("R1 range", 64'({bipolar_o, gain_o}), 64'h0);
    chk("R8 ready", 64'(req_ready), 64'h1);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][79], VEC[i][78], VEC[i][77:72], VEC[i][71:56]);
      chk(TAG[i], 64'(dac_code_o), 64'(VEC[i][55:8]));
      chk(TAG[i], 64'({bipolar_o, gain_o}), 64'(VEC[i][7:0]));
    end
    // R1 reset mid-run clears shadow and control state
    rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1;
    chk("R1 codes after reset", 64'(dac_code_o), 64'(MID4));
    chk("R1 range after reset", 64'({bipolar_o, gain_o}), 64'h0);
    drive(1, 1, 6'h02, 16'h0002);
    chk("R1 shadow cleared", 64'(dac_code_o), 64'h0);
    chk("R6 enable", 64'(dac_en_o), 64'h1);
    drive(1, 0, 6'h12, 16'h0000);
    chk("R1 control cleared", 64'({bipolar_o, gain_o}), 64'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule